// File: doc/BRIEF.md
# Fractional Clock Divider with Per-Edge Phase Residue

This block derives several output clocks from one fast input clock. Each output path divides by a ratio made of an integer part and a fraction. The integer part is N. The fraction is num/den, where den is at least 1 and num is less than den. No single integer divider can produce such a ratio. The path therefore chooses, one output period at a time, between a period of N input cycles and a period of N+1 input cycles. A modulo-den accumulator makes that choice, so the average period equals the requested ratio exactly.

At every output edge the path also reports the accumulator residue. The residue is the distance, in units of 1/den input cycles, between the edge the path actually produced and the ideal edge. A later phase-adjust stage uses this word to pull each edge back onto the ideal waveform. All paths run from the same input clock and are fully independent of one another.

Ratio inputs are observed only at period boundaries. A path takes a new ratio only when the value on its inputs differs from the ratio it is running. Taking a new ratio restarts that path's accumulator from zero. Behaviour is specified for N of at least 2.

Top module: `fdiv_top`

## Requirements
- R1: While reset is high, every divided clock, every edge strobe and every phase-error word is 0.
- R2: Every output period lasts either N or N+1 input cycles of the path's active ratio.
- R3: Starting from a ratio load, the first den periods add up to exactly den*N + num input cycles.
- R4: The phase-error word seen at the k-th edge after a load equals (k*num) mod den, and it is always smaller than den.
- R5: A period lasts N+1 cycles exactly when adding num to the previous residue reaches den or more. Otherwise it lasts N cycles.
- R6: Within a period of length d, the divided clock is high for the first floor(d/2) input cycles and low for the remaining cycles.
- R7: When num is 0, every period lasts exactly N cycles and the phase-error word stays 0.
- R8: A ratio change made in the middle of a period does not alter that period. The new ratio takes effect at the next edge, and its first phase-error word is num, because the accumulator restarts from zero.
- R9: Loading a new ratio on one path leaves the period lengths and phase-error words of every other path unchanged.
- R10: The edge strobe is high for exactly one input cycle per period, in the first cycle of the period, and the divided clock is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared high-rate input clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_int_i | input | NUM_PATHS*INT_W | Integer part N for each path; path p occupies bits [p*INT_W +: INT_W] |
| ratio_num_i | input | NUM_PATHS*FRAC_W | Fraction numerator for each path; path p occupies bits [p*FRAC_W +: FRAC_W] |
| ratio_den_i | input | NUM_PATHS*FRAC_W | Fraction denominator for each path, at least 1; path p occupies bits [p*FRAC_W +: FRAC_W] |
| div_clk_o | output | NUM_PATHS | Divided clock for each path |
| edge_o | output | NUM_PATHS | High in the first input cycle of each output period |
| phase_err_o | output | NUM_PATHS*FRAC_W | Residue for each path, valid while that path's edge_o is high |

## Verification
The bench builds the block with its default parameters: four paths, an 8-bit integer part and 8-bit fraction fields. Four paths are enough to hold one path at a steady integer ratio while a neighbouring path is reconfigured repeatedly, and to run different fractional ratios side by side. Eight-bit fraction fields allow denominators such as 7 and 8. Those denominators produce residue cycles long enough to exercise carries from several different residue values, and to check the exact period sum over a whole accumulator cycle. Odd and even period lengths both occur, which covers the rounding in the duty split.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    parameter int INT_W  = 8;
    parameter int FRAC_W = 8;
    localparam int DIV_W = INT_W + 1;

    // Ratio applied to one path: n + num/den
    typedef struct packed {
        logic [INT_W-1:0]  n;
        logic [FRAC_W-1:0] num;
        logic [FRAC_W-1:0] den;
    } ratio_t;

    // Result of one accumulator step: next residue and chosen period length
    typedef struct packed {
        logic [FRAC_W-1:0] res;
        logic [DIV_W-1:0]  div;
    } step_t;

    function automatic step_t frac_step(input logic [FRAC_W-1:0] acc, input ratio_t r);
        logic [FRAC_W:0] sum;
        step_t           s;
        sum = {1'b0, acc} + {1'b0, r.num};
        if (sum >= {1'b0, r.den}) begin
            s.res = FRAC_W'(sum - {1'b0, r.den});
            s.div = DIV_W'(r.n) + DIV_W'(1);
        end else begin
            s.res = sum[FRAC_W-1:0];
            s.div = DIV_W'(r.n);
        end
        return s;
    endfunction

endpackage

// File: rtl/fdiv_frac_acc.sv
module fdiv_frac_acc
    import fdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary,
    input  ratio_t            cfg,
    output logic [DIV_W-1:0]  div_next,
    output logic [FRAC_W-1:0] res_o,
    output ratio_t            act_o
);

    ratio_t            act_q;
    logic [FRAC_W-1:0] res_q;
    logic              reload;
    logic [FRAC_W-1:0] base;
    step_t             step;

    // A different ratio on the inputs restarts the residue from zero
    always_comb begin
        reload   = (cfg != act_q);
        base     = reload ? '0 : res_q;
        step     = frac_step(base, reload ? cfg : act_q);
        div_next = step.div;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            res_q <= '0;
        end else if (boundary) begin
            if (reload) begin
                act_q <= cfg;
            end
            res_q <= step.res;
        end
    end

    assign res_o = res_q;
    assign act_o = act_q;

endmodule

// File: rtl/fdiv_int_cnt.sv
module fdiv_int_cnt
    import fdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_next,
    output logic             boundary,
    output logic             clk_o,
    output logic             edge_o,
    output logic [DIV_W-1:0] cur_div_o
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;
    logic             run_q;

    assign boundary = (cnt_q == div_q - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            div_q <= DIV_W'(1);
            run_q <= 1'b0;
        end else if (boundary) begin
            cnt_q <= '0;
            div_q <= div_next;
            run_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign clk_o     = run_q && (cnt_q < (div_q >> 1));
    assign edge_o    = run_q && (cnt_q == '0);
    assign cur_div_o = div_q;

endmodule

// File: rtl/fdiv_path.sv
module fdiv_path
    import fdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ratio_t            cfg,
    output logic              clk_o,
    output logic              edge_o,
    output logic [FRAC_W-1:0] err_o,
    output ratio_t            act_o,
    output logic [DIV_W-1:0]  cur_div_o
);

    logic             boundary;
    logic [DIV_W-1:0] div_next;

    fdiv_frac_acc u_acc (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .cfg      (cfg),
        .div_next (div_next),
        .res_o    (err_o),
        .act_o    (act_o)
    );

    fdiv_int_cnt u_cnt (
        .clk       (clk),
        .rst       (rst),
        .div_next  (div_next),
        .boundary  (boundary),
        .clk_o     (clk_o),
        .edge_o    (edge_o),
        .cur_div_o (cur_div_o)
    );

endmodule

// File: rtl/fdiv_top.sv
module fdiv_top
    import fdiv_pkg::*;
#(
    parameter int NUM_PATHS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PATHS*INT_W-1:0]    ratio_int_i,
    input  logic [NUM_PATHS*FRAC_W-1:0]   ratio_num_i,
    input  logic [NUM_PATHS*FRAC_W-1:0]   ratio_den_i,
    output logic [NUM_PATHS-1:0]          div_clk_o,
    output logic [NUM_PATHS-1:0]          edge_o,
    output logic [NUM_PATHS*FRAC_W-1:0]   phase_err_o
);

    ratio_t [NUM_PATHS-1:0]            act_w;
    logic   [NUM_PATHS-1:0][DIV_W-1:0] cur_div_w;

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        ratio_t cfg;
        assign cfg.n   = ratio_int_i[p*INT_W +: INT_W];
        assign cfg.num = ratio_num_i[p*FRAC_W +: FRAC_W];
        assign cfg.den = ratio_den_i[p*FRAC_W +: FRAC_W];

        fdiv_path u_path (
            .clk       (clk),
            .rst       (rst),
            .cfg       (cfg),
            .clk_o     (div_clk_o[p]),
            .edge_o    (edge_o[p]),
            .err_o     (phase_err_o[p*FRAC_W +: FRAC_W]),
            .act_o     (act_w[p]),
            .cur_div_o (cur_div_w[p])
        );
    end

endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk
    import fdiv_pkg::*;
#(
    parameter int NUM_PATHS = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_PATHS-1:0]          div_clk_o,
    input logic [NUM_PATHS-1:0]          edge_o,
    input logic [NUM_PATHS*FRAC_W-1:0]   phase_err_o,
    input ratio_t [NUM_PATHS-1:0]        act_w,
    input logic [NUM_PATHS-1:0][DIV_W-1:0] cur_div_w
);

    // R1: outputs quiet in the cycle after a reset edge
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (edge_o == '0 && div_clk_o == '0 && phase_err_o == '0));

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_chk
        a_r10_edge_high: assert property (@(posedge clk) disable iff (rst)
            edge_o[p] |-> div_clk_o[p]);

        a_r10_edge_single: assert property (@(posedge clk) disable iff (rst)
            edge_o[p] |=> !edge_o[p]);

        a_r4_err_below_den: assert property (@(posedge clk) disable iff (rst)
            edge_o[p] |-> (phase_err_o[p*FRAC_W +: FRAC_W] < act_w[p].den));

        a_r7_integer_no_err: assert property (@(posedge clk) disable iff (rst)
            (edge_o[p] && act_w[p].num == '0) |-> (phase_err_o[p*FRAC_W +: FRAC_W] == '0));

        a_r2_div_range: assert property (@(posedge clk) disable iff (rst)
            edge_o[p] |-> (cur_div_w[p] == DIV_W'(act_w[p].n) ||
                           cur_div_w[p] == DIV_W'(act_w[p].n) + DIV_W'(1)));

        a_r8_load_at_edge: assert property (@(posedge clk) disable iff (rst)
            !edge_o[p] |-> $stable(act_w[p]));
    end

endmodule

bind fdiv_top fdiv_chk #(.NUM_PATHS(NUM_PATHS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .div_clk_o   (div_clk_o),
    .edge_o      (edge_o),
    .phase_err_o (phase_err_o),
    .act_w       (act_w),
    .cur_div_w   (cur_div_w)
);

// File: tb/tb_fdiv_top.sv
module tb_fdiv_top;
    import fdiv_pkg::*;

    localparam int P = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [P*INT_W-1:0]   ratio_int_i;
    logic [P*FRAC_W-1:0]  ratio_num_i;
    logic [P*FRAC_W-1:0]  ratio_den_i;
    logic [P-1:0]         div_clk_o;
    logic [P-1:0]         edge_o;
    logic [P*FRAC_W-1:0]  phase_err_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    fdiv_top #(.NUM_PATHS(P)) dut (
        .clk         (clk),
        .rst         (rst),
        .ratio_int_i (ratio_int_i),
        .ratio_num_i (ratio_num_i),
        .ratio_den_i (ratio_den_i),
        .div_clk_o   (div_clk_o),
        .edge_o      (edge_o),
        .phase_err_o (phase_err_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected at most 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_ratio(input int p, input int n, input int num, input int den);
        ratio_int_i[p*INT_W +: INT_W]   = INT_W'(n);
        ratio_num_i[p*FRAC_W +: FRAC_W] = FRAC_W'(num);
        ratio_den_i[p*FRAC_W +: FRAC_W] = FRAC_W'(den);
    endtask

    task automatic sync_edge(input int p);
        @(negedge clk);
        while (!edge_o[p]) @(negedge clk);
    endtask

    // Entered at the negedge of an edge cycle; leaves at the next edge cycle
    task automatic get_period(input int p, output int len, output int hi, output int err, output bit start_hi);
        err      = int'(phase_err_o[p*FRAC_W +: FRAC_W]);
        start_hi = div_clk_o[p];
        len = 0;
        hi  = 0;
        do begin
            if (div_clk_o[p]) hi++;
            len++;
            @(negedge clk);
        end while (!edge_o[p]);
    endtask

    // Checks a run of periods that starts at a freshly loaded ratio
    task automatic check_seq(input int p, input int n, input int num, input int den, input int periods, input string tag);
        int acc = 0;
        int total = 0;
        for (int k = 0; k < periods; k++) begin
            int len, hi, err, exp_len;
            bit start_hi, carry;
            acc += num;
            carry = (acc >= den);
            if (carry) acc -= den;
            exp_len = n + (carry ? 1 : 0);
            get_period(p, len, hi, err, start_hi);
            check(len == exp_len, "R2 R5", {tag, " period length"}, len, exp_len);
            check(err == acc, "R4", {tag, " phase residue"}, err, acc);
            check(hi == exp_len / 2, "R6", {tag, " high cycles"}, hi, exp_len / 2);
            check(start_hi == 1'b1, "R10", {tag, " clock high at edge"}, int'(start_hi), 1);
            if (num == 0) check(err == 0, "R7", {tag, " integer residue"}, err, 0);
            if (k < den) total += len;
            if (k == den - 1) check(total == den * n + num, "R3", {tag, " period sum"}, total, den * n + num);
        end
    endtask

    task automatic run_ratio(input int p, input int n, input int num, input int den, input int periods, input string tag);
        set_ratio(p, n, num, den);
        sync_edge(p);
        check_seq(p, n, num, den, periods, tag);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(div_clk_o == '0, "R1", "clock in reset", int'(div_clk_o), 0);
            check(edge_o == '0, "R1", "edge in reset", int'(edge_o), 0);
            check(phase_err_o == '0, "R1", "residue in reset", int'(phase_err_o), 0);
        end
        rst = 1'b0;
    endtask

    task automatic t_integer;
        run_ratio(0, 5, 0, 1, 6, "r7_int5");
    endtask

    task automatic t_fraction;
        run_ratio(0, 4, 3, 8, 16, "r3_frac4_3_8");
        run_ratio(2, 10, 5, 7, 14, "r4_frac10_5_7");
    endtask

    task automatic t_odd;
        run_ratio(0, 7, 1, 2, 4, "r6_odd7_1_2");
    endtask

    task automatic t_midchange;
        int rem;
        run_ratio(0, 9, 0, 1, 2, "r8_old9");
        repeat (4) @(negedge clk);
        set_ratio(0, 3, 2, 3);
        rem = 0;
        while (!edge_o[0]) begin
            rem++;
            @(negedge clk);
        end
        check(rem == 5, "R8", "remaining old period", rem, 5);
        check(int'(phase_err_o[0 +: FRAC_W]) == 2, "R8", "first residue after load",
              int'(phase_err_o[0 +: FRAC_W]), 2);
        check_seq(0, 3, 2, 3, 6, "r8_new3_2_3");
    endtask

    task automatic t_paths;
        set_ratio(1, 6, 0, 1);
        run_ratio(3, 5, 2, 5, 10, "r9_path3");
        sync_edge(1);
        fork
            check_seq(1, 6, 0, 1, 12, "r9_path1_steady");
            begin
                for (int i = 0; i < 6; i++) begin
                    repeat (7) @(negedge clk);
                    set_ratio(0, 2 + i, i, 6);
                end
            end
        join
    endtask

    initial begin
        for (int p = 0; p < P; p++) set_ratio(p, 4, 0, 1);
        t_reset();
        t_integer();
        t_fraction();
        t_odd();
        t_midchange();
        t_paths();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule